// File: doc/BRIEF.md
# Privilege-Gated User Counter Access

This block is a slice of a core's control and status register file. It holds a free-running cycle counter, a retired-instruction counter and two counter-enable words, one owned by machine mode and one by supervisor mode. It also decides, for each CSR read, whether the current privilege level may see the addressed register. Every read request gets one registered response, which carries either the register value or an illegal-instruction flag with zeroed data.

The rule for user-mode counter reads depends on a static hardware input that says whether supervisor mode is built in. When supervisor mode exists, a user read needs the matching enable bit in both enable words. When it does not exist, the machine enable bit alone decides, and the supervisor enable word does not exist either. The ISA description register reports the same hardware property, so software can find it.

Top module: `ctr_gate`

## Requirements
- R1: While reset is high and on the first cycle after it, both counters, both enable words and all outputs are zero.
- R2: The cycle counter counts every clock edge after reset. A read at 0xC00 returns the number of non-reset edges before the edge that sampled the request.
- R3: The retired counter counts edges at which `retire` is high. A read at 0xC02 returns the count from before the sampling edge.
- R4: Privilege encoding is 00 user, 01 supervisor, 11 machine. In machine mode a counter read is always permitted.
- R5: In supervisor mode a counter read is permitted only when the machine enable bit indexed by address bits [4:0] is set (bit 0 for 0xC00, bit 2 for 0xC02).
- R6: In user mode with `smode_present` high, a counter read needs the indexed bit set in both the machine and the supervisor enable words.
- R7: In user mode with `smode_present` low, the indexed machine enable bit alone grants the read. A set bit at any other position grants nothing.
- R8: A denied read sets `illegal_o` and returns all-zero data.
- R9: Address 0x301 returns the ISA word. Bit 18 equals `smode_present`, bit 20 is 1 and all other bits are 0. It is readable only in machine mode.
- R10: The machine enable word is written and read at 0x306, and reading it needs machine mode. The supervisor enable word sits at 0x106 and is readable from supervisor mode up. When `smode_present` is low, any access to 0x106 is illegal, reads as zero, and writes to it are dropped.
- R11: Any other address, including 0xC01, is illegal.
- R12: `rd_ok_o` is high exactly one cycle after each cycle with `rd_valid` high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_valid | input | 1 | CSR read request |
| rd_addr | input | 12 | CSR read address |
| priv | input | 2 | Current privilege level |
| retire | input | 1 | One instruction retired this cycle |
| smode_present | input | 1 | Supervisor mode is implemented (static) |
| wr_en | input | 1 | Enable-word write strobe |
| wr_addr | input | 12 | Write address (0x306 or 0x106) |
| wr_data | input | 32 | Write data |
| rd_ok_o | output | 1 | Read response valid |
| illegal_o | output | 1 | Read was denied |
| rd_data_o | output | 64 | Read data, zero when denied |

## Verification
Each read response comes one cycle after its request. The design samples the request on a rising edge and registers the response on that same edge, and the response holds until the next edge. The driver applies a request on a falling edge and queues the expected result, and the monitor pops it on the following falling edge, when the response is stable. The expected counter values come from counts the bench keeps of non-reset edges and of retire pulses. These counts are taken at the moment of issue, which matches the value the design captures before that edge's increment. An enable write lands on the edge after it is driven, so every read issued after a write task sees the new value.

// File: rtl/ctr_gate_pkg.sv
`timescale 1ns/1ps
package ctr_gate_pkg;
  typedef enum logic [1:0] {
    LVL_USER  = 2'b00,
    LVL_SUPER = 2'b01,
    LVL_RSVD  = 2'b10,
    LVL_MACH  = 2'b11
  } lvl_e;

  localparam logic [11:0] ADDR_CYC  = 12'hC00;
  localparam logic [11:0] ADDR_RET  = 12'hC02;
  localparam logic [11:0] ADDR_MEN  = 12'h306;
  localparam logic [11:0] ADDR_SEN  = 12'h106;
  localparam logic [11:0] ADDR_ISA  = 12'h301;
  localparam int          ISA_S_POS = 18;
  localparam int          ISA_U_POS = 20;
endpackage

// File: rtl/ctr_gate_counters.sv
`timescale 1ns/1ps
module ctr_gate_counters #(
  parameter int CW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          retire,
  output logic [CW-1:0] cyc_o,
  output logic [CW-1:0] ret_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_o <= '0;
      ret_o <= '0;
    end else begin
      cyc_o <= cyc_o + 1'b1;
      if (retire) ret_o <= ret_o + 1'b1;
    end
  end
endmodule

// File: rtl/ctr_gate_enables.sv
`timescale 1ns/1ps
module ctr_gate_enables
  import ctr_gate_pkg::*;
#(
  parameter int EW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smode_present,
  input  logic          wr_en,
  input  logic [11:0]   wr_addr,
  input  logic [EW-1:0] wr_data,
  output logic [EW-1:0] men_o,
  output logic [EW-1:0] sen_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      men_o <= '0;
      sen_o <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_MEN) men_o <= wr_data;
      if (wr_addr == ADDR_SEN && smode_present) sen_o <= wr_data;
    end
  end
endmodule

// File: rtl/ctr_gate_decide.sv
`timescale 1ns/1ps
module ctr_gate_decide
  import ctr_gate_pkg::*;
#(
  parameter int CW = 64,
  parameter int EW = 32
) (
  input  logic [11:0]   addr,
  input  logic [1:0]    priv,
  input  logic          smode_present,
  input  logic [EW-1:0] men,
  input  logic [EW-1:0] sen,
  input  logic [CW-1:0] cyc,
  input  logic [CW-1:0] ret,
  output logic          legal_o,
  output logic [CW-1:0] data_o
);
  localparam int IW = $clog2(EW);

  lvl_e          lvl;
  logic [IW-1:0] idx;
  logic          hit, is_ctr, lvl_ok, ctr_ok, m_bit, s_bit;
  logic [CW-1:0] raw, isa_word;

  always_comb begin
    lvl      = lvl_e'(priv);
    idx      = addr[IW-1:0];
    m_bit    = men[idx];
    s_bit    = sen[idx];
    isa_word = '0;
    isa_word[ISA_S_POS] = smode_present;
    isa_word[ISA_U_POS] = 1'b1;
    lvl_ok   = (priv >= addr[9:8]);
    hit      = 1'b1;
    is_ctr   = 1'b0;
    raw      = '0;
    case (addr)
      ADDR_CYC: begin is_ctr = 1'b1; raw = cyc; end
      ADDR_RET: begin is_ctr = 1'b1; raw = ret; end
      ADDR_MEN: raw = CW'(men);
      ADDR_SEN: begin hit = smode_present; raw = CW'(sen); end
      ADDR_ISA: raw = isa_word;
      default:  hit = 1'b0;
    endcase
    case (lvl)
      LVL_MACH:  ctr_ok = 1'b1;
      LVL_SUPER: ctr_ok = m_bit;
      LVL_USER:  ctr_ok = smode_present ? (m_bit & s_bit) : m_bit;
      default:   ctr_ok = 1'b0;
    endcase
    legal_o = hit && lvl_ok && (!is_ctr || ctr_ok);
    data_o  = legal_o ? raw : '0;
  end
endmodule

// File: rtl/ctr_gate.sv
`timescale 1ns/1ps
module ctr_gate #(
  parameter int CW = 64,
  parameter int EW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_valid,
  input  logic [11:0]   rd_addr,
  input  logic [1:0]    priv,
  input  logic          retire,
  input  logic          smode_present,
  input  logic          wr_en,
  input  logic [11:0]   wr_addr,
  input  logic [EW-1:0] wr_data,
  output logic          rd_ok_o,
  output logic          illegal_o,
  output logic [CW-1:0] rd_data_o
);
  logic [CW-1:0] cyc_w, ret_w, dec_data;
  logic [EW-1:0] men_w, sen_w;
  logic          dec_legal;

  ctr_gate_counters #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .retire(retire), .cyc_o(cyc_w), .ret_o(ret_w)
  );

  ctr_gate_enables #(.EW(EW)) u_en (
    .clk(clk), .rst(rst), .smode_present(smode_present), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .men_o(men_w), .sen_o(sen_w)
  );

  ctr_gate_decide #(.CW(CW), .EW(EW)) u_dec (
    .addr(rd_addr), .priv(priv), .smode_present(smode_present),
    .men(men_w), .sen(sen_w), .cyc(cyc_w), .ret(ret_w),
    .legal_o(dec_legal), .data_o(dec_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ok_o   <= 1'b0;
      illegal_o <= 1'b0;
      rd_data_o <= '0;
    end else begin
      rd_ok_o   <= rd_valid;
      illegal_o <= rd_valid && !dec_legal;
      rd_data_o <= rd_valid ? dec_data : '0;
    end
  end
endmodule

// File: rtl/ctr_gate_checker.sv
`timescale 1ns/1ps
module ctr_gate_checker #(
  parameter int CW = 64,
  parameter int EW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_valid,
  input logic [11:0]   rd_addr,
  input logic [1:0]    priv,
  input logic          smode_present,
  input logic          rd_ok_o,
  input logic          illegal_o,
  input logic [CW-1:0] rd_data_o,
  input logic [CW-1:0] cyc,
  input logic [EW-1:0] men,
  input logic [EW-1:0] sen
);
  assert_resp_follows_R12: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> rd_ok_o);
  assert_no_stray_resp_R12: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |=> !rd_ok_o);
  assert_denied_zero_R8: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (rd_ok_o && rd_data_o == '0));
  assert_cycle_steps_R2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> cyc == $past(cyc) + 1'b1);
  assert_mach_counter_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && priv == 2'b11 && rd_addr == 12'hC00) |=> !illegal_o);
  assert_user_both_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && priv == 2'b00 && smode_present && rd_addr == 12'hC00 && !sen[0])
      |=> illegal_o);
  assert_user_mach_only_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && priv == 2'b00 && !smode_present && rd_addr == 12'hC00 && men[0])
      |=> !illegal_o);
endmodule

bind ctr_gate ctr_gate_checker #(.CW(CW), .EW(EW)) u_chk (
  .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_addr(rd_addr), .priv(priv),
  .smode_present(smode_present), .rd_ok_o(rd_ok_o), .illegal_o(illegal_o),
  .rd_data_o(rd_data_o), .cyc(cyc_w), .men(men_w), .sen(sen_w)
);

// File: tb/ctr_gate_bench.sv
`timescale 1ns/1ps
module ctr_gate_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_valid = 1'b0;
  logic [11:0] rd_addr = '0;
  logic [1:0]  priv = 2'b11;
  logic        retire = 1'b0;
  logic        smode_present = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_ok_o, illegal_o;
  logic [63:0] rd_data_o;

  int checks = 0, fails = 0;
  bit done = 0;
  longint unsigned bench_cyc = 0;
  longint unsigned bench_ret = 0;
  logic [31:0] model_men = '0, model_sen = '0;

  logic        q_ill[$];
  logic [63:0] q_dat[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;

  ctr_gate u_ctr_gate (
    .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_addr(rd_addr), .priv(priv),
    .retire(retire), .smode_present(smode_present), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_ok_o(rd_ok_o),
    .illegal_o(illegal_o), .rd_data_o(rd_data_o)
  );

  always @(posedge clk) bench_cyc <= rst ? 64'd0 : bench_cyc + 64'd1;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected item one cycle after issue
  always @(negedge clk) begin
    if (!rst && rd_ok_o) begin
      if (q_ill.size() == 0) begin
        check(0, "R12 unexpected response", 64'd1, 64'd0);
      end else begin
        logic ei; logic [63:0] ed; string t;
        ei = q_ill.pop_front(); ed = q_dat.pop_front(); t = q_tag.pop_front();
        check(illegal_o == ei, {t, " illegal"}, 64'(illegal_o), 64'(ei));
        check(rd_data_o == ed, {t, " data"}, rd_data_o, ed);
      end
    end
  end

  function automatic bit model_legal(input logic [11:0] a, input logic [1:0] p,
                                     input bit sp);
    bit m, s;
    m = model_men[a[4:0]];
    s = model_sen[a[4:0]];
    if (a == 12'hC00 || a == 12'hC02) begin
      if (p == 2'b11) return 1;
      if (p == 2'b01) return m;
      if (p == 2'b00) return sp ? (m && s) : m;
      return 0;
    end
    if (a == 12'h301 || a == 12'h306) return p == 2'b11;
    if (a == 12'h106) return sp && (p == 2'b01 || p == 2'b11);
    return 0;
  endfunction

  function automatic logic [63:0] model_val(input logic [11:0] a, input bit sp);
    case (a)
      12'hC00: return bench_cyc;
      12'hC02: return bench_ret;
      12'h306: return 64'(model_men);
      12'h106: return 64'(model_sen);
      12'h301: return (64'(sp) << 18) | (64'd1 << 20);
      default: return 64'd0;
    endcase
  endfunction

  task automatic do_reset(input bit sp);
    @(negedge clk);
    rst = 1'b1; smode_present = sp;
    repeat (2) @(negedge clk);
    check(rd_ok_o == 0 && illegal_o == 0 && rd_data_o == 0, "R1 outputs in reset",
          rd_data_o, 64'd0);
    rst = 1'b0;
    bench_ret = 0; model_men = '0; model_sen = '0;
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    if (a == 12'h306) model_men = d;
    if (a == 12'h106 && smode_present) model_sen = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_retire(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); retire = 1'b1;
      @(negedge clk); retire = 1'b0;
      bench_ret++;
    end
  endtask

  task automatic do_read(input logic [11:0] a, input logic [1:0] p, input string tag);
    bit lg;
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a; priv = p;
    lg = model_legal(a, p, smode_present);
    q_ill.push_back(!lg);
    q_dat.push_back(lg ? model_val(a, smode_present) : 64'd0);
    q_tag.push_back($sformatf("%s a=%h p=%0d sp=%0d", tag, a, p, smode_present));
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  initial begin
    // R1: reset state observed through reads
    do_reset(1'b0);
    do_read(12'h306, 2'b11, "R1 men after reset");
    do_read(12'hC02, 2'b11, "R1 ret after reset");
    // R2, R3: counters
    repeat (7) @(negedge clk);
    do_read(12'hC00, 2'b11, "R2 cycle");
    do_retire(5);
    do_read(12'hC02, 2'b11, "R3 retired");
    do_read(12'hC00, 2'b11, "R2 cycle later");
    // R9, R10, R11 with supervisor absent
    do_read(12'h301, 2'b11, "R9 isa no S");
    do_read(12'h301, 2'b00, "R9 isa from user");
    do_write(12'h106, 32'hFFFF_FFFF);
    do_read(12'h106, 2'b11, "R10 sen absent");
    do_read(12'hC01, 2'b11, "R11 time addr");
    do_read(12'h7FF, 2'b11, "R11 unknown addr");
    // R7 boundary: only a neighbouring bit set
    do_write(12'h306, 32'h0000_0002);
    do_read(12'hC00, 2'b00, "R7 wrong bit");
    do_read(12'h306, 2'b00, "R10 men from user");
    // sweep: R4 R5 R6 R7 R8
    for (int sp = 0; sp < 2; sp++) begin
      do_reset(sp[0]);
      do_read(12'h301, 2'b11, "R9 isa");
      for (int pi = 0; pi < 3; pi++) begin
        logic [1:0] p;
        p = (pi == 0) ? 2'b00 : (pi == 1) ? 2'b01 : 2'b11;
        if (sp == 0 && p == 2'b01) continue;
        for (int c = 0; c < 4; c++) begin
          do_write(12'h306, c[0] ? 32'h5 : 32'h0);
          do_write(12'h106, c[1] ? 32'h5 : 32'h0);
          do_retire(1);
          do_read(12'hC00, p, "R4/R5/R6/R7/R8 sweep cycle");
          do_read(12'hC02, p, "R4/R5/R6/R7/R8 sweep ret");
          do_read(12'h106, p, "R10 sen sweep");
        end
      end
    end
    repeat (3) @(negedge clk);
    check(q_ill.size() == 0, "R12 missing responses", 64'(q_ill.size()), 64'd0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R12 watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule